// File: doc/BRIEF.md
# SDRAM Clock-Enable Low-Power State Tracker

This block follows a synchronous DRAM device through its clock-enable driven low-power modes. On every clock it samples the clock-enable pin and the four active-low command pins, together with a flag that says whether every bank is precharged. It keeps the clock-enable value from the previous cycle. A falling clock-enable with a quiet command or an auto-refresh command moves it into power-down or self-refresh. A rising clock-enable brings it out again.

The tracker sits beside a memory controller or on a bus monitor. It publishes the device's current low-power state and a ready flag that says ordinary commands may be issued. It raises a one-cycle pulse whenever the command seen on a clock-enable transition, or during the recovery wait, breaks the entry and exit rules. After a self-refresh exit the device is held in a recovery state for a configurable number of row-cycle clocks before it counts as idle again.

Top module: `sdram_lp_tracker`

## Requirements
- R1: After reset the state is normal (code 0), the illegal pulse is low and ready is high. The previous clock-enable is taken as low, so a low clock-enable on the first cycles after reset enters no mode.
- R2: In the normal state with all banks idle, if clock-enable was high on the previous cycle and is low now, and the command is a deselect (cs_n=1) or a NOP (cs_n=0, ras_n=cas_n=we_n=1), the state becomes power-down (code 1).
- R3: Under the same conditions as R2, an auto-refresh command (cs_n=ras_n=cas_n=0, we_n=1) makes the state self-refresh (code 2).
- R4: Under the same conditions as R2, any other command pulses illegal and leaves the state normal.
- R5: In the normal state, a high-to-low clock-enable while banks_idle is low pulses illegal and leaves the state normal, whatever the command.
- R6: In the normal state without a high-to-low clock-enable transition, the state stays normal and no illegal pulse is raised, for any command.
- R7: In power-down or self-refresh, a low clock-enable keeps the mode with no illegal pulse, for any command pins.
- R8: In power-down, a high clock-enable with a deselect or NOP returns the state to normal on that edge.
- R9: In self-refresh, a high clock-enable with a deselect or NOP moves the state to row-cycle wait (code 3). The state stays there for exactly RC_CYCLES clocks and then becomes normal. With RC_CYCLES of 0 it returns to normal directly.
- R10: In either low-power mode, a high clock-enable with any command other than deselect or NOP pulses illegal and keeps the mode.
- R11: During the row-cycle wait, clock-enable is ignored, and every command other than deselect or NOP pulses illegal without changing the countdown.
- R12: Ready is high exactly when the state is normal. The illegal pulse lasts one cycle and is registered on the same edge that samples the offending command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock-enable pin as sampled |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when every bank is precharged |
| state_o | output | 2 | 0 normal, 1 power-down, 2 self-refresh, 3 row-cycle wait |
| illegal_o | output | 1 | One-cycle pulse for a rule-breaking command |
| ready_o | output | 1 | High in the normal state |

## Verification
The bench builds the tracker with RC_CYCLES set to 4 rather than the default 8. This keeps the recovery wait short, so random traffic reaches self-refresh exits many times and lands commands on the first, middle and last cycles of the wait. Biased random clock-enable and command streams, with banks_idle mostly high, drive many entries and exits from both modes. The same streams also produce rejected entries while banks are busy and exit cycles that carry real commands. Directed sequences cover the first cycles after reset and exact-length recovery.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [1:0] {
    LP_NORMAL = 2'd0,
    LP_PDOWN  = 2'd1,
    LP_SREF   = 2'd2,
    LP_RCWAIT = 2'd3
  } lp_state_t;

  typedef enum logic [1:0] {
    CMD_QUIET = 2'd0,
    CMD_AREF  = 2'd1,
    CMD_OTHER = 2'd2
  } cmd_kind_t;

  // Deselect or NOP is quiet; CS/RAS/CAS low with WE high is auto-refresh.
  function automatic cmd_kind_t classify_cmd(input logic cs_n, input logic ras_n,
                                             input logic cas_n, input logic we_n);
    if (cs_n || (ras_n && cas_n && we_n)) return CMD_QUIET;
    if (!ras_n && !cas_n && we_n)          return CMD_AREF;
    return CMD_OTHER;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdram_cmd_class.sv
module sdram_cmd_class
  import sdram_lp_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_t kind
);
  always_comb kind = classify_cmd(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdram_rc_timer.sv
module sdram_rc_timer #(
  parameter int RC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (RC_CYCLES > 1) ? $clog2(RC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RC_CYCLES > 0 ? RC_CYCLES - 1 : 0);

  generate
    if (RC_CYCLES > 0) begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = load || (run && (cnt_q != '0));
        cnt_d  = load ? LOAD_VAL : cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign done = (cnt_q == '0);
    end else begin : g_none
      assign done = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/sdram_lp_fsm.sv
module sdram_lp_fsm
  import sdram_lp_pkg::*;
#(
  parameter int RC_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke,
  input  cmd_kind_t kind,
  input  logic      banks_idle,
  input  logic      tmr_done,
  output logic      tmr_load,
  output logic      tmr_run,
  output lp_state_t state_q,
  output logic      cke_prev_q,
  output logic      illegal_q
);
  localparam bit HAS_WAIT = (RC_CYCLES > 0);

  lp_state_t state_d;
  logic      illegal_d;

  always_comb begin
    state_d   = state_q;
    illegal_d = 1'b0;
    tmr_load  = 1'b0;
    tmr_run   = (state_q == LP_RCWAIT);
    unique case (state_q)
      LP_NORMAL: begin
        if (cke_prev_q && !cke) begin
          if (!banks_idle)             illegal_d = 1'b1;
          else if (kind == CMD_QUIET)  state_d   = LP_PDOWN;
          else if (kind == CMD_AREF)   state_d   = LP_SREF;
          else                         illegal_d = 1'b1;
        end
      end
      LP_PDOWN, LP_SREF: begin
        if (cke) begin
          if (kind != CMD_QUIET) begin
            illegal_d = 1'b1;
          end else if (state_q == LP_PDOWN || !HAS_WAIT) begin
            state_d = LP_NORMAL;
          end else begin
            state_d  = LP_RCWAIT;
            tmr_load = 1'b1;
          end
        end
      end
      LP_RCWAIT: begin
        if (kind != CMD_QUIET) illegal_d = 1'b1;
        if (tmr_done)          state_d   = LP_NORMAL;
      end
      default: state_d = LP_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LP_NORMAL;
      cke_prev_q <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cke_prev_q <= cke;
      illegal_q  <= illegal_d;
    end
  end
endmodule

// File: rtl/sdram_lp_tracker.sv
module sdram_lp_tracker
  import sdram_lp_pkg::*;
#(
  parameter int RC_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [1:0] state_o,
  output logic       illegal_o,
  output logic       ready_o
);
  logic      rst_int_n;
  cmd_kind_t kind;
  logic      tmr_load;
  logic      tmr_run;
  logic      tmr_done;
  lp_state_t state_q;
  logic      cke_prev_q;
  logic      illegal_q;

  sdram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sdram_cmd_class u_class (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .kind  (kind)
  );

  sdram_rc_timer #(.RC_CYCLES(RC_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (tmr_load),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  sdram_lp_fsm #(.RC_CYCLES(RC_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cke        (cke),
    .kind       (kind),
    .banks_idle (banks_idle),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run),
    .state_q    (state_q),
    .cke_prev_q (cke_prev_q),
    .illegal_q  (illegal_q)
  );

  assign state_o   = state_q;
  assign illegal_o = illegal_q;
  assign ready_o   = (state_q == LP_NORMAL);
endmodule

// File: rtl/sdram_lp_tracker_chk.sv
module sdram_lp_tracker_chk #(
  parameter int RC_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       banks_idle,
  input logic [1:0] state_o,
  input logic       illegal_o,
  input logic       cke_prev
);
  localparam logic [1:0] S_NORM = 2'd0;
  localparam logic [1:0] S_PD   = 2'd1;
  localparam logic [1:0] S_SR   = 2'd2;
  localparam logic [1:0] S_WAIT = 2'd3;
  localparam int CW = $clog2(RC_CYCLES + 2);

  logic quiet;
  assign quiet = cs_n || (ras_n && cas_n && we_n);

  logic [CW-1:0] wait_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wait_cyc <= '0;
    else if (state_o == S_WAIT)  wait_cyc <= wait_cyc + 1'b1;
    else                         wait_cyc <= '0;
  end

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_NORM && cke_prev && !cke && !banks_idle) |=> (illegal_o && state_o == S_NORM)); // R5

  AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == S_PD || state_o == S_SR) && !cke) |=> ($stable(state_o) && !illegal_o)); // R7

  AST_PD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_PD && cke && quiet) |=> (state_o == S_NORM && !illegal_o)); // R8

  AST_WAIT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_WAIT && !quiet) |=> illegal_o); // R11

  AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_NORM && !(cke_prev && !cke)) |=> (state_o == S_NORM && !illegal_o)); // R6

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_WAIT) |-> (int'(wait_cyc) < RC_CYCLES)); // R9

  AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == S_WAIT && state_o != S_WAIT) |-> (int'(wait_cyc) == RC_CYCLES)); // R9
endmodule

bind sdram_lp_tracker sdram_lp_tracker_chk #(.RC_CYCLES(RC_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .banks_idle (banks_idle),
  .state_o    (state_o),
  .illegal_o  (illegal_o),
  .cke_prev   (cke_prev_q)
);

// File: tb/sdram_lp_tracker_tb.sv
module sdram_lp_tracker_tb;
  localparam int RC = 4;

  logic       clk;
  logic       rst_n;
  logic       cke, cs_n, ras_n, cas_n, we_n, banks_idle;
  logic [1:0] state_o;
  logic       illegal_o, ready_o;

  int n_chk;
  int n_fail;

  // Bench reference state
  logic [1:0] m_state;
  logic       m_ckeq;
  int         m_wait;
  logic       m_ill;

  sdram_lp_tracker #(.RC_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle),
    .state_o(state_o), .illegal_o(illegal_o), .ready_o(ready_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // 0 quiet, 1 auto-refresh, 2 other
  function automatic int kind_of(input logic c, input logic r, input logic a, input logic w);
    if (c || (r && a && w)) return 0;
    if (!r && !a && w)      return 1;
    return 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Drive one cycle, advance the reference, then compare 5 ns after the edge.
  task automatic step(input logic k, input logic c, input logic r, input logic a,
                      input logic w, input logic idle);
    string tag;
    int kd;
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; banks_idle = idle;
    kd = kind_of(c, r, a, w);
    m_ill = 1'b0;
    tag = "R6";
    case (m_state)
      2'd0: if (m_ckeq && !k) begin
        if (!idle)        begin tag = "R5"; m_ill = 1'b1; end
        else if (kd == 0) begin tag = "R2"; m_state = 2'd1; end
        else if (kd == 1) begin tag = "R3"; m_state = 2'd2; end
        else              begin tag = "R4"; m_ill = 1'b1; end
      end
      2'd1, 2'd2: begin
        if (!k) tag = "R7";
        else if (kd != 0) begin tag = "R10"; m_ill = 1'b1; end
        else if (m_state == 2'd1) begin tag = "R8"; m_state = 2'd0; end
        else begin
          tag = "R9";
          if (RC == 0) m_state = 2'd0;
          else begin m_state = 2'd3; m_wait = RC; end
        end
      end
      default: begin
        tag = "R11";
        if (kd != 0) m_ill = 1'b1;
        m_wait--;
        if (m_wait == 0) begin m_state = 2'd0; tag = "R9"; end
      end
    endcase
    m_ckeq = k;
    @(posedge clk);
    #5;
    check({tag, " state"}, int'(state_o), int'(m_state));
    check({tag, " illegal"}, int'(illegal_o), int'(m_ill));
    check("R12 ready", int'(ready_o), int'(m_state == 2'd0));
  endtask

  task automatic nop(input logic k, input logic idle);
    step(k, 1'b0, 1'b1, 1'b1, 1'b1, idle);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    n_chk = 0; n_fail = 0;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    cke = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; banks_idle = 1'b1;
    m_state = 2'd0; m_ckeq = 1'b0; m_wait = 0; m_ill = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    check("R1 state", int'(state_o), 0);
    check("R1 illegal", int'(illegal_o), 0);
    check("R1 ready", int'(ready_o), 1);
    // R1: low clock-enable right after reset is no entry
    nop(1'b0, 1'b1);
    check("R1 no entry", int'(state_o), 0);
    // R2 then R8
    nop(1'b1, 1'b1);
    nop(1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R7 with a real command held
    nop(1'b1, 1'b1);
    // R3, R10 exit with a command, then R9 exact wait
    nop(1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1); // R11 activate in wait, cke ignored
    for (int i = 0; i < RC + 1; i++) nop(1'b1, 1'b1);
    // R5 busy entry and R4 bad entry
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    nop(1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    nop(1'b1, 1'b1);
    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      logic k, c, r, a, w, idle;
      int sel;
      k    = ($urandom % 100) < 65;
      idle = ($urandom % 100) < 85;
      sel  = $urandom % 10;
      if (sel < 4)      begin c = 1'b0; r = 1'b1; a = 1'b1; w = 1'b1; end
      else if (sel < 5) begin c = 1'b1; r = 1'($urandom); a = 1'($urandom); w = 1'($urandom); end
      else if (sel < 7) begin c = 1'b0; r = 1'b0; a = 1'b0; w = 1'b1; end
      else              begin c = 1'b0; r = 1'($urandom); a = 1'($urandom); w = 1'($urandom); end
      step(k, c, r, a, w, idle);
    end
    finish_run();
  end
endmodule